// File: doc/BRIEF.md
# Transition Timing Jitter Meter

This block grades every transition on an oversampled biphase-mark audio line against a locked local timebase. The timebase arrives as a tick phase within the unit interval (16 ticks per UI, phase 0 on the ideal grid point). Each graded transition gives a signed deviation in ticks. Over a measurement window of a programmable number of frames the block keeps the largest early and the largest late deviation. At the window end it publishes them together with their peak-to-peak sum, an over-allowance flag, a count of ambiguous transitions and the shortest pulse seen inside preambles.

A recovered position code says where each line sample falls in the subframe, and a mode input selects which transitions are graded. Intrinsic mode grades only edges in the late part of the Y preamble. Those edges carry no data-pattern jitter, so the value shows the source's own jitter. Data mode grades only edges inside the audio data fields, which exposes cable-induced, pattern-dependent jitter. Independently of the mode, the block measures the width of pulses bounded by two preamble edges. How far short pulses fall below one UI indicates high-frequency line loss without depending on the audio content.

The controller has two states. In `ST_IDLE` nothing is published. The first frame start moves it to `ST_MEASURE` and clears the accumulators. In `ST_MEASURE`, a frame start that completes the window publishes the results, clears the accumulators and restarts the frame count. Any other frame start only advances the count.

Top module: `jitter_meter`

## Requirements
- R1: While reset is held, and until the first window is published, `result_valid` is 0 and `early_mag`, `late_mag`, `pp_out`, `over_limit` and `err_count` are 0. `runt_min` resets to 255.
- R2: A transition is the cycle in which `line_in` differs from its value in the previous cycle. Its deviation is read from `ui_phase` in that cycle. A phase p from 1 to 7 is late by p ticks, a phase p from 9 to 15 is early by 16-p ticks, and phase 0 has no deviation.
- R3: `zone` codes are 0 other, 1 preamble (early part), 2 late Y preamble, 3 audio data. With `mode`=0 only zone-2 transitions are graded. With `mode`=1 only zone-3 transitions are graded. All other transitions leave the jitter results unchanged.
- R4: `early_mag` and `late_mag` are the largest early and late magnitudes graded in the window, both starting from 0. `pp_out` is their sum.
- R5: A graded transition at phase 8 (half a UI) is ambiguous. It increments `err_count` (saturating at 255) and does not affect `early_mag` or `late_mag`.
- R6: `over_limit` is 1 exactly when the published `pp_out` exceeds 4 ticks (about 40 ns at a 48 kHz frame rate).
- R7: A window ends at the frame start that brings the count of frame starts since the window began to `win_len`. A `win_len` of 0 acts as 1. Accumulation restarts with that frame start's own cycle.
- R8: The published outputs change only in the cycle after a window-ending frame start, and `result_valid` stays 1 once set.
- R9: `runt_min` is the smallest interval, in clock cycles, between two consecutive transitions that both lie in zone 1 or 2 within the window, whatever the mode. It is 255 if there is no such pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversample clock, 16 ticks per UI |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Oversampled line level |
| ui_phase | input | 4 | Timebase tick within the UI, 0 on the grid |
| zone | input | 2 | Position code of the current sample |
| mode | input | 1 | 0 intrinsic (late Y preamble), 1 data fields |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| win_len | input | 8 | Frames per measurement window |
| early_mag | output | 4 | Largest early deviation, ticks |
| late_mag | output | 4 | Largest late deviation, ticks |
| pp_out | output | 5 | Peak-to-peak deviation, ticks |
| over_limit | output | 1 | Peak-to-peak above allowance |
| err_count | output | 8 | Ambiguous transitions in window |
| runt_min | output | 8 | Shortest preamble pulse, cycles |
| result_valid | output | 1 | A window has been published |

## Verification
On every cycle the assertions check four properties of the outputs. The results hold still except right after a window-ending frame start, the peak-to-peak value is the sum of the two magnitudes, the flag agrees with the threshold, and neither magnitude reaches half a UI. They also check that nothing is reported before the first publication. Only the bench scenarios can show the arithmetic of the deviations. The same holds for which edges each mode admits, the handling of ambiguous phases, the window length counting including the zero case, and the minimum pulse width. Each of these depends on a stimulus history that a single-cycle property cannot see.

// File: rtl/jm_pkg.sv
package jm_pkg;
    typedef enum logic [1:0] {
        ZN_OTHER = 2'd0,
        ZN_PRE   = 2'd1,
        ZN_YLATE = 2'd2,
        ZN_DATA  = 2'd3
    } zone_t;

    typedef enum logic {
        ST_IDLE,
        ST_MEASURE
    } state_t;
endpackage

// File: rtl/jm_edge_grader.sv
module jm_edge_grader #(
    parameter int TICKS = 16,
    localparam int PH_W = $clog2(TICKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_in,
    input  logic [PH_W-1:0] phase,
    input  logic [1:0]      zone,
    input  logic            mode,
    output logic            edge_o,
    output logic            pre_edge_o,
    output logic            graded_o,
    output logic            ambig_o,
    output logic [PH_W-1:0] early_o,
    output logic [PH_W-1:0] late_o
);
    import jm_pkg::*;

    localparam logic [PH_W-1:0] HALF = PH_W'(TICKS / 2);
    localparam logic [PH_W:0]   FULL = (PH_W + 1)'(TICKS);

    logic           line_q;
    zone_t          zn;
    logic           in_gate;
    logic [PH_W:0]  back;

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_in;
    end

    assign zn         = zone_t'(zone);
    assign edge_o     = line_in ^ line_q;
    assign pre_edge_o = edge_o && (zn == ZN_PRE || zn == ZN_YLATE);
    assign in_gate    = mode ? (zn == ZN_DATA) : (zn == ZN_YLATE);
    assign ambig_o    = edge_o && in_gate && (phase == HALF);
    assign graded_o   = edge_o && in_gate && (phase != HALF);
    assign back       = FULL - {1'b0, phase};
    assign late_o     = (phase < HALF) ? phase : '0;
    assign early_o    = (phase > HALF) ? back[PH_W-1:0] : '0;
endmodule

// File: rtl/jm_extreme_tracker.sv
module jm_extreme_tracker #(
    parameter int MAG_W = 4,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             graded,
    input  logic             ambig,
    input  logic [MAG_W-1:0] early_in,
    input  logic [MAG_W-1:0] late_in,
    output logic [MAG_W-1:0] early_acc,
    output logic [MAG_W-1:0] late_acc,
    output logic [ERR_W-1:0] err_acc
);
    logic [MAG_W-1:0] base_e, base_l;
    logic [ERR_W-1:0] base_x;

    assign base_e = clear ? '0 : early_acc;
    assign base_l = clear ? '0 : late_acc;
    assign base_x = clear ? '0 : err_acc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_acc <= '0;
            late_acc  <= '0;
            err_acc   <= '0;
        end else begin
            early_acc <= (graded && early_in > base_e) ? early_in : base_e;
            late_acc  <= (graded && late_in > base_l) ? late_in : base_l;
            err_acc   <= (ambig && base_x != '1) ? base_x + 1'b1 : base_x;
        end
    end
endmodule

// File: rtl/jm_runt_meter.sv
module jm_runt_meter #(
    parameter int RUNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              edge_i,
    input  logic              pre_edge_i,
    output logic [RUNT_W-1:0] runt_acc
);
    logic [RUNT_W-1:0] gap_q;
    logic [RUNT_W-1:0] width;
    logic [RUNT_W-1:0] base;
    logic              prev_pre_q;

    assign width = (gap_q == '1) ? gap_q : gap_q + 1'b1;
    assign base  = clear ? '1 : runt_acc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q      <= '0;
            prev_pre_q <= 1'b0;
            runt_acc   <= '1;
        end else begin
            if (edge_i) begin
                gap_q      <= '0;
                prev_pre_q <= pre_edge_i;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
            runt_acc <= (pre_edge_i && prev_pre_q && width < base) ? width : base;
        end
    end
endmodule

// File: rtl/jitter_meter.sv
module jitter_meter #(
    parameter int TICKS_PER_UI = 16,
    parameter int LIMIT_TICKS  = 4,
    parameter int ERR_W        = 8,
    parameter int RUNT_W       = 8,
    parameter int WIN_W        = 8,
    localparam int PH_W        = $clog2(TICKS_PER_UI)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic [PH_W-1:0]   ui_phase,
    input  logic [1:0]        zone,
    input  logic              mode,
    input  logic              frame_start,
    input  logic [WIN_W-1:0]  win_len,
    output logic [PH_W-1:0]   early_mag,
    output logic [PH_W-1:0]   late_mag,
    output logic [PH_W:0]     pp_out,
    output logic              over_limit,
    output logic [ERR_W-1:0]  err_count,
    output logic [RUNT_W-1:0] runt_min,
    output logic              result_valid
);
    import jm_pkg::*;

    localparam logic [PH_W:0] LIM = (PH_W + 1)'(LIMIT_TICKS);

    state_t            state_q, state_n;
    logic [WIN_W-1:0]  frm_q, frm_n, win_eff;
    logic              clear, publish;
    logic              edge_w, pre_edge_w, graded_w, ambig_w;
    logic [PH_W-1:0]   early_w, late_w, early_acc, late_acc;
    logic [ERR_W-1:0]  err_acc;
    logic [RUNT_W-1:0] runt_acc;
    logic [PH_W:0]     pp_nxt;

    jm_edge_grader #(.TICKS(TICKS_PER_UI)) u_grader (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .phase(ui_phase),
        .zone(zone), .mode(mode), .edge_o(edge_w), .pre_edge_o(pre_edge_w),
        .graded_o(graded_w), .ambig_o(ambig_w), .early_o(early_w), .late_o(late_w)
    );

    jm_extreme_tracker #(.MAG_W(PH_W), .ERR_W(ERR_W)) u_extreme (
        .clk(clk), .rst_n(rst_n), .clear(clear), .graded(graded_w),
        .ambig(ambig_w), .early_in(early_w), .late_in(late_w),
        .early_acc(early_acc), .late_acc(late_acc), .err_acc(err_acc)
    );

    jm_runt_meter #(.RUNT_W(RUNT_W)) u_runt (
        .clk(clk), .rst_n(rst_n), .clear(clear), .edge_i(edge_w),
        .pre_edge_i(pre_edge_w), .runt_acc(runt_acc)
    );

    assign win_eff = (win_len == '0) ? WIN_W'(1) : win_len;
    assign pp_nxt  = {1'b0, early_acc} + {1'b0, late_acc};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            frm_q   <= '0;
        end else begin
            state_q <= state_n;
            frm_q   <= frm_n;
        end
    end

    // next state and control
    always_comb begin
        state_n = state_q;
        frm_n   = frm_q;
        clear   = 1'b0;
        publish = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_start) begin
                    state_n = ST_MEASURE;
                    clear   = 1'b1;
                    frm_n   = WIN_W'(1);
                end
            end
            ST_MEASURE: begin
                if (frame_start) begin
                    if (frm_q >= win_eff) begin
                        publish = 1'b1;
                        clear   = 1'b1;
                        frm_n   = WIN_W'(1);
                    end else begin
                        frm_n = frm_q + 1'b1;
                    end
                end
            end
        endcase
    end

    // published results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_mag    <= '0;
            late_mag     <= '0;
            pp_out       <= '0;
            over_limit   <= 1'b0;
            err_count    <= '0;
            runt_min     <= '1;
            result_valid <= 1'b0;
        end else if (publish) begin
            early_mag    <= early_acc;
            late_mag     <= late_acc;
            pp_out       <= pp_nxt;
            over_limit   <= pp_nxt > LIM;
            err_count    <= err_acc;
            runt_min     <= runt_acc;
            result_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/jm_checker.sv
module jm_checker #(
    parameter int TICKS_PER_UI = 16,
    parameter int LIMIT_TICKS  = 4,
    parameter int ERR_W        = 8,
    parameter int RUNT_W       = 8,
    localparam int PH_W        = $clog2(TICKS_PER_UI)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic [PH_W-1:0]   early_mag,
    input logic [PH_W-1:0]   late_mag,
    input logic [PH_W:0]     pp_out,
    input logic              over_limit,
    input logic [ERR_W-1:0]  err_count,
    input logic [RUNT_W-1:0] runt_min,
    input logic              result_valid
);
    localparam logic [PH_W:0] LIM  = (PH_W + 1)'(LIMIT_TICKS);
    localparam logic [PH_W:0] HALF = (PH_W + 1)'(TICKS_PER_UI / 2);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> (pp_out == '0 && err_count == '0 && !over_limit));

    assert_pp_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pp_out == {1'b0, early_mag} + {1'b0, late_mag});

    assert_mag_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, early_mag} < HALF) && ({1'b0, late_mag} < HALF));

    assert_over_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        over_limit == (pp_out > LIM));

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_start) |-> ($stable(pp_out) && $stable(err_count) && $stable(runt_min)));

    assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> result_valid);
endmodule

bind jitter_meter jm_checker #(
    .TICKS_PER_UI(TICKS_PER_UI), .LIMIT_TICKS(LIMIT_TICKS),
    .ERR_W(ERR_W), .RUNT_W(RUNT_W)
) u_jm_checker (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .early_mag(early_mag), .late_mag(late_mag), .pp_out(pp_out),
    .over_limit(over_limit), .err_count(err_count), .runt_min(runt_min),
    .result_valid(result_valid)
);

// File: tb/test_jitter_meter.sv
`timescale 1ns/1ps
module test_jitter_meter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b0;
    logic [3:0] ui_phase = '0;
    logic [1:0] zone = '0;
    logic       mode = 1'b0;
    logic       frame_start = 1'b0;
    logic [7:0] win_len = 8'd1;
    logic [3:0] early_mag, late_mag;
    logic [4:0] pp_out;
    logic       over_limit, result_valid;
    logic [7:0] err_count, runt_min;

    jitter_meter i_jitter_meter (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .ui_phase(ui_phase),
        .zone(zone), .mode(mode), .frame_start(frame_start), .win_len(win_len),
        .early_mag(early_mag), .late_mag(late_mag), .pp_out(pp_out),
        .over_limit(over_limit), .err_count(err_count), .runt_min(runt_min),
        .result_valid(result_valid)
    );

    always #2.5 clk = ~clk;

    typedef struct { int early; int late; int err; int runt; string tag; } exp_t;
    exp_t q[$];
    exp_t last;
    bit   have_last = 0;
    bit   pub_pending = 0;
    bit   done = 0;
    int   checks = 0, errors = 0;

    int m_early = 0, m_late = 0, m_err = 0, m_runt = 255, m_fcnt = 0, m_last_edge = 0, cyc = 0;
    bit m_idle = 1, m_prev_pre = 0, line_v = 0;
    string cur_tag = "";

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus plus the requirement model
    task automatic step(input bit tog, input int ph, input int zn, input bit fs);
        bit pub = 0, clr = 0, meas, pre;
        int w, wl;
        @(negedge clk);
        if (tog) line_v = !line_v;
        line_in = line_v; ui_phase = 4'(ph); zone = 2'(zn); frame_start = fs;
        cyc++;
        wl = (win_len == 0) ? 1 : int'(win_len);
        if (fs) begin
            if (m_idle) begin m_idle = 0; clr = 1; m_fcnt = 1; end
            else if (m_fcnt >= wl) begin
                q.push_back('{m_early, m_late, m_err, m_runt, cur_tag});
                pub = 1; clr = 1; m_fcnt = 1;
            end else m_fcnt++;
        end
        if (clr) begin m_early = 0; m_late = 0; m_err = 0; m_runt = 255; end
        if (tog) begin
            meas = (mode == 0 && zn == 2) || (mode == 1 && zn == 3);
            if (meas) begin
                if (ph == 8) begin if (m_err < 255) m_err++; end
                else if (ph > 8) begin if (16 - ph > m_early) m_early = 16 - ph; end
                else if (ph > m_late) m_late = ph;
            end
            pre = (zn == 1 || zn == 2);
            w = cyc - m_last_edge;
            if (w > 255) w = 255;
            if (pre && m_prev_pre && w < m_runt) m_runt = w;
            m_prev_pre = pre; m_last_edge = cyc;
        end
        @(posedge clk); #1;
        if (pub) pub_pending = 1;
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    // monitor: pops the scoreboard when a window is published
    always @(negedge clk) begin
        if (pub_pending) begin
            exp_t e;
            pub_pending = 0;
            if (q.size() == 0) check("R7", "unexpected publish", 1, 0);
            else begin
                int pp;
                e = q.pop_front();
                pp = e.early + e.late;
                check(e.tag, "early_mag", int'(early_mag), e.early);
                check(e.tag, "late_mag", int'(late_mag), e.late);
                check({e.tag, " R4"}, "pp_out", int'(pp_out), pp);
                check("R6", "over_limit", int'(over_limit), (pp > 4) ? 1 : 0);
                check({e.tag, " R5"}, "err_count", int'(err_count), e.err);
                check({e.tag, " R9"}, "runt_min", int'(runt_min), e.runt);
                check("R8", "result_valid", int'(result_valid), 1);
                last = e; have_last = 1;
            end
        end else if (have_last && rst_n) begin
            check("R8", "pp_out held", int'(pp_out), last.early + last.late);
            check("R8", "runt_min held", int'(runt_min), last.runt);
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", "valid in reset", int'(result_valid), 0);
        check("R1", "pp in reset", int'(pp_out), 0);
        check("R1", "err in reset", int'(err_count), 0);
        check("R1", "runt in reset", int'(runt_min), 255);
        rst_n = 1'b1;
        quiet(3);
        check("R1", "valid before window", int'(result_valid), 0);

        // R2 R3 intrinsic mode: zone 2 graded, zone 3 and 1 ignored
        cur_tag = "R2 R3 intrinsic"; mode = 0; win_len = 1;
        step(0, 0, 0, 1);
        check("R1", "valid after first start", int'(result_valid), 0);
        step(1, 3, 2, 0); quiet(3);
        step(1, 14, 2, 0); quiet(3);
        step(1, 6, 3, 0); quiet(2);
        step(1, 11, 1, 0); quiet(2);
        step(0, 0, 0, 1);

        // R3 data mode: zone 3 graded, zone 2 ignored
        cur_tag = "R2 R3 data"; mode = 1;
        step(1, 1, 3, 0); quiet(2);
        step(1, 15, 3, 0); quiet(2);
        step(1, 7, 2, 0); quiet(2);
        step(0, 0, 0, 1);

        // R5 ambiguous half-UI edges, R6 boundary at exactly 4
        cur_tag = "R5 R6 boundary";
        step(1, 8, 3, 0); quiet(1);
        step(1, 8, 3, 0); quiet(1);
        step(1, 4, 3, 0); quiet(1);
        step(1, 0, 3, 0); quiet(1);
        step(0, 0, 0, 1);

        // R7 three-frame window, results held in between (R8)
        cur_tag = "R7 window3"; win_len = 3; mode = 0;
        step(1, 2, 2, 0); quiet(4);
        step(0, 0, 0, 1);
        step(1, 12, 2, 0); quiet(4);
        step(0, 0, 0, 1);
        step(1, 6, 2, 0); quiet(4);
        step(0, 0, 0, 1);

        // R7 zero length acts as one frame
        cur_tag = "R7 zero length"; win_len = 0;
        step(1, 13, 2, 0); quiet(2);
        step(0, 0, 0, 1);

        // R9 preamble pulse widths, data pulses excluded
        cur_tag = "R9 runt"; win_len = 1; mode = 1;
        step(1, 0, 1, 0); quiet(15);
        step(1, 0, 1, 0); quiet(15);
        step(1, 0, 1, 0); quiet(12);
        step(1, 0, 1, 0); quiet(4);
        step(1, 0, 3, 0); quiet(4);
        step(1, 0, 3, 0); quiet(19);
        step(1, 0, 2, 0); quiet(2);
        step(0, 0, 0, 1);

        // R4 R9 empty window
        cur_tag = "R4 R9 empty"; quiet(10);
        step(0, 0, 0, 1);

        // R6 large spread sets the flag in data mode
        cur_tag = "R6 over";
        step(1, 7, 3, 0); quiet(2);
        step(1, 9, 3, 0); quiet(2);
        step(0, 0, 0, 1);
        quiet(3);

        check("R7", "pending expectations", q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule